// File: doc/BRIEF.md
# Adaptive Bit-Tree Symbol Decoder

This block decodes one multi-bit symbol per request by walking a binary tree of adaptive bit probabilities. Each tree node is an 11-bit probability held in a local single-port RAM. A built-in binary range-decoding datapath turns these probabilities, together with a compressed byte stream, into decoded bits. After each decoded bit, the probability used for that bit is adapted towards the outcome and written back to the RAM.

The block supports three ways of walking the tree:
- **Forward walk.** Bits arrive most significant first. A sentinel leading one keeps each node index unique. A caller-supplied addend finishes the symbol, for example to strip the sentinel or to add a base offset.
- **Fixed four-bit reverse walk.** Bits arrive least significant first. Node indices are built from power-of-two offsets.
- **Variable-length reverse walk.** Each decoded one adds a per-step weight into a destination accumulator.

After reset, the block first pulls five initialisation bytes into its code register. It then accepts requests. While it is busy, it pulls further bytes on demand whenever its range falls below 2^24.

Top module: `bt_tree_decoder`

## Requirements
- R1: During and straight after reset, done is 0, symbol and dest are 0, and byte_req is 1 because initialisation bytes are pending.
- R2: After reset, the first five accepted bytes shift into the 32-bit code register, most significant first. The range starts at 0xFFFFFFFF. A start pulse given before these five bytes are taken is ignored and produces no done.
- R3: mode 0 (forward) with bit count N in 1..8 runs exactly N bit steps.
  - Each step first loads the probability at the node index. The node index is the low 8 bits of the working symbol, which starts at 1.
  - Each step then updates the working symbol to symbol*2 + bit.
  - mode 3 behaves as mode 0.
- R4: After the last forward step, the 16-bit addend is added to the symbol modulo 2^16. With an addend of -(2^N), the result is below 2^N.
- R5: mode 1 (fixed reverse) ignores nbits and always runs 4 steps.
  - The working symbol starts at 0.
  - Step i (i = 0..3) uses node index symbol + 2^i.
  - Step i adds 2^i to the symbol when the decoded bit is 1.
- R6: mode 2 (variable reverse) works as follows.
  - At start, dest is cleared and the working symbol is set to 1.
  - Each of N steps uses the node at the working symbol, then sets the symbol to symbol*2 + bit.
  - Step i adds add_val shifted left by i to dest when the bit is 1.
  - Modes 0 and 1 leave dest unchanged.
- R7: Each bit is decoded as follows.
  - bound = (range >> 11) * prob, where prob is the node's probability.
  - The bit is 1 when code >= bound.
  - On a 1, range and code each decrease by bound. On a 0, range becomes bound.
  - Before the decision, if range < 2^24, the block shifts range and code left by 8 bits and places the next byte into the low byte of code.
- R8: Every probability starts at 1024.
  - After a 0 bit, p becomes p + ((2048 - p) >> 5). After a 1 bit, p becomes p - (p >> 5).
  - The new value is written back to the index it was read from.
- R9: done is high for exactly one cycle per request. symbol and dest change only in the cycle where done is high.
- R10: A start pulse while a request is in progress is ignored.
- R11: byte_req is high only while initialising or while waiting to normalise. A byte is taken only in a cycle where byte_req and byte_vld are both high. When byte_vld is low, the block stalls without losing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| mode | input | 2 | 0 forward, 1 fixed 4-bit reverse, 2 variable reverse, 3 as forward |
| nbits | input | 4 | Bit count for forward and variable reverse (1..8) |
| addend | input | 16 | Final addend for forward mode (two's complement) |
| add_val | input | 16 | Step-0 weight for variable reverse mode; doubles each step |
| byte_vld | input | 1 | Input byte available |
| byte_dat | input | 8 | Input byte |
| byte_req | output | 1 | Block wants a byte this cycle |
| symbol | output | 16 | Decoded symbol |
| dest | output | 16 | Accumulated destination value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach from the ports is a probability that has been adapted many times. Such a value is reused later by another walk that shares the same RAM nodes. A write-back error therefore only shows up several requests after it happens.

To reach this, the stimulus runs long sequences of mixed forward, reverse and variable requests over one pseudo-random byte stream. A bench-side range-decoding model tracks every node. The byte source also drops its valid signal in a fixed gap pattern, so normalisation stalls land at varying points within the bit sequence.

// File: rtl/bt_tree_pkg.sv
// Shared types for the bit-tree decoder.
package bt_tree_pkg;
    typedef enum logic [1:0] {
        MODE_FWD  = 2'd0,
        MODE_REV4 = 2'd1,
        MODE_VAR  = 2'd2,
        MODE_FWD2 = 2'd3
    } walk_mode_e;

    typedef enum logic [2:0] {
        ST_INIT = 3'd0,
        ST_IDLE = 3'd1,
        ST_RD   = 3'd2,
        ST_NORM = 3'd3,
        ST_BIT  = 3'd4,
        ST_DONE = 3'd5
    } walk_state_e;
endpackage

// File: rtl/bt_prob_ram.sv
// Single-port probability store with synchronous read.
// Assumes read and write never share a cycle; every entry resets to half scale.
module bt_prob_ram #(
    parameter int PROB_W = 11,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [PROB_W-1:0] wdata,
    output logic [PROB_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [PROB_W-1:0] HALF = PROB_W'(1) << (PROB_W - 1);

    logic [PROB_W-1:0] mem [DEPTH];

    // Storage: reset to half scale, write on we, registered read on re.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= HALF;
            rdata <= '0;
        end else begin
            if (we) mem[addr] <= wdata;
            if (re) rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/bt_range_core.sv
// Combinational binary range-decoding step with probability adaptation.
// Assumes range and code are already normalised.
module bt_range_core #(
    parameter int RNG_W  = 32,
    parameter int PROB_W = 11,
    parameter int MOVE_W = 5
) (
    input  logic [RNG_W-1:0]  rng,
    input  logic [RNG_W-1:0]  code,
    input  logic [PROB_W-1:0] prob,
    output logic              bit_o,
    output logic [RNG_W-1:0]  rng_n,
    output logic [RNG_W-1:0]  code_n,
    output logic [PROB_W-1:0] prob_n
);
    localparam logic [PROB_W:0] TOTAL = (PROB_W+1)'(1) << PROB_W;

    logic [RNG_W-1:0] bound;
    logic [PROB_W:0]  up;

    // Split point, decision and state update for one bit.
    always_comb begin
        bound  = (rng >> PROB_W) * RNG_W'(prob);
        bit_o  = (code >= bound);
        up     = (TOTAL - {1'b0, prob}) >> MOVE_W;
        if (bit_o) begin
            rng_n  = rng - bound;
            code_n = code - bound;
            prob_n = prob - (prob >> MOVE_W);
        end else begin
            rng_n  = bound;
            code_n = code;
            prob_n = prob + up[PROB_W-1:0];
        end
    end
endmodule

// File: rtl/bt_index_gen.sv
// Node index from the working symbol: direct for forward and variable walks,
// symbol plus 2^step for the fixed reverse walk.
module bt_index_gen #(
    parameter int SYM_W = 16,
    parameter int IDX_W = 8,
    parameter int CNT_W = 4
) (
    input  logic [1:0]       mode,
    input  logic [SYM_W-1:0] sym,
    input  logic [CNT_W-1:0] step,
    output logic [IDX_W-1:0] idx
);
    import bt_tree_pkg::*;

    // Index selection per walk type.
    always_comb begin
        if (walk_mode_e'(mode) == MODE_REV4)
            idx = sym[IDX_W-1:0] + (IDX_W'(1) << step);
        else
            idx = sym[IDX_W-1:0];
    end
endmodule

// File: rtl/bt_tree_decoder.sv
// Bit-tree symbol decoder: sequences read / normalise / decide+write per bit.
// Assumes one request at a time; starts outside the idle state are dropped.
module bt_tree_decoder #(
    parameter int PROB_W     = 11,
    parameter int IDX_W      = 8,
    parameter int SYM_W      = 16,
    parameter int CNT_W      = 4,
    parameter int RNG_W      = 32,
    parameter int MOVE_W     = 5,
    parameter int INIT_BYTES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] nbits,
    input  logic [SYM_W-1:0] addend,
    input  logic [SYM_W-1:0] add_val,
    input  logic             byte_vld,
    input  logic [7:0]       byte_dat,
    output logic             byte_req,
    output logic [SYM_W-1:0] symbol,
    output logic [SYM_W-1:0] dest,
    output logic             done
);
    import bt_tree_pkg::*;

    localparam logic [RNG_W-1:0] TOP = RNG_W'(1) << (RNG_W - 8);
    localparam int IB_W = $clog2(INIT_BYTES + 1);

    walk_state_e       state;
    walk_mode_e        mode_q;
    logic [RNG_W-1:0]  rng, code, rng_n, code_n;
    logic [SYM_W-1:0]  sym_w, dest_w, sym_nx, dest_nx, addend_q, addv_q;
    logic [CNT_W-1:0]  step, cnt;
    logic [IB_W-1:0]   ibytes;
    logic [IDX_W-1:0]  ram_addr;
    logic [PROB_W-1:0] prob_q, prob_n;
    logic              ram_we, ram_re, dbit, need_byte, last, st_bit, st_idle;

    assign st_bit    = (state == ST_BIT);
    assign st_idle   = (state == ST_IDLE);
    assign ram_we    = st_bit;
    assign ram_re    = (state == ST_RD);
    assign need_byte = (rng < TOP);
    assign byte_req  = (state == ST_INIT) || ((state == ST_NORM) && need_byte);
    assign done      = (state == ST_DONE);
    assign last      = (step == cnt - CNT_W'(1));

    bt_index_gen #(.SYM_W(SYM_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_idx (
        .mode(mode_q), .sym(sym_w), .step(step), .idx(ram_addr)
    );

    bt_prob_ram #(.PROB_W(PROB_W), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .re(ram_re), .we(ram_we),
        .addr(ram_addr), .wdata(prob_n), .rdata(prob_q)
    );

    bt_range_core #(.RNG_W(RNG_W), .PROB_W(PROB_W), .MOVE_W(MOVE_W)) u_core (
        .rng(rng), .code(code), .prob(prob_q),
        .bit_o(dbit), .rng_n(rng_n), .code_n(code_n), .prob_n(prob_n)
    );

    // Next working symbol and accumulator for the bit being decided.
    always_comb begin
        if (mode_q == MODE_REV4)
            sym_nx = sym_w + (SYM_W'(dbit) << step);
        else
            sym_nx = {sym_w[SYM_W-2:0], dbit};
        if ((mode_q == MODE_FWD || mode_q == MODE_FWD2) && last)
            sym_nx = sym_nx + addend_q;
        dest_nx = dest_w;
        if (mode_q == MODE_VAR && dbit)
            dest_nx = dest_w + (addv_q << step);
    end

    // Sequencer and range-decoder state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            mode_q   <= MODE_FWD;
            rng      <= '1;
            code     <= '0;
            ibytes   <= '0;
            sym_w    <= '0;
            dest_w   <= '0;
            step     <= '0;
            cnt      <= '0;
            addend_q <= '0;
            addv_q   <= '0;
            symbol   <= '0;
            dest     <= '0;
        end else begin
            case (state)
                ST_INIT: if (byte_vld) begin
                    code   <= {code[RNG_W-9:0], byte_dat};
                    ibytes <= ibytes + IB_W'(1);
                    if (ibytes == IB_W'(INIT_BYTES - 1)) state <= ST_IDLE;
                end
                ST_IDLE: if (start) begin
                    mode_q   <= walk_mode_e'(mode);
                    cnt      <= (walk_mode_e'(mode) == MODE_REV4) ? CNT_W'(4) : nbits;
                    sym_w    <= (walk_mode_e'(mode) == MODE_REV4) ? '0 : SYM_W'(1);
                    if (walk_mode_e'(mode) == MODE_VAR) dest_w <= '0;
                    step     <= '0;
                    addend_q <= addend;
                    addv_q   <= add_val;
                    state    <= ST_RD;
                end
                ST_RD: state <= ST_NORM;
                ST_NORM: begin
                    if (!need_byte) begin
                        state <= ST_BIT;
                    end else if (byte_vld) begin
                        rng   <= rng << 8;
                        code  <= {code[RNG_W-9:0], byte_dat};
                        state <= ST_BIT;
                    end
                end
                ST_BIT: begin
                    rng    <= rng_n;
                    code   <= code_n;
                    sym_w  <= sym_nx;
                    dest_w <= dest_nx;
                    step   <= step + CNT_W'(1);
                    if (last) begin
                        symbol <= sym_nx;
                        dest   <= dest_nx;
                        state  <= ST_DONE;
                    end else begin
                        state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// Protocol and datapath checks for the bit-tree decoder.
module bt_tree_decoder_chk #(
    parameter int SYM_W = 16,
    parameter int IDX_W = 8,
    parameter int RNG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [SYM_W-1:0] symbol,
    input logic [SYM_W-1:0] dest,
    input logic             byte_req,
    input logic             st_bit,
    input logic             st_idle,
    input logic [RNG_W-1:0] rng,
    input logic             ram_we,
    input logic [IDX_W-1:0] ram_addr,
    input logic [1:0]       mode_q
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(symbol) && $stable(dest)));
    // R8
    wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == $past(ram_addr)));
    // R11
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !byte_req);
    // R7
    norm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_bit |-> (rng >= (RNG_W'(1) << (RNG_W - 8))));
    // R5
    rev_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && mode_q == 2'd1) |-> (ram_addr < IDX_W'(16)));
endmodule

bind bt_tree_decoder bt_tree_decoder_chk #(.SYM_W(SYM_W), .IDX_W(IDX_W), .RNG_W(RNG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .symbol(symbol), .dest(dest),
    .byte_req(byte_req), .st_bit(st_bit), .st_idle(st_idle), .rng(rng),
    .ram_we(ram_we), .ram_addr(ram_addr), .mode_q(mode_q)
);

// File: tb/sim_bt_tree_decoder.sv
module sim_bt_tree_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  n;
        logic [15:0] addend;
        logic [15:0] addv;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'd0, 4'd3, 16'hFFF8, 16'h0000},
        '{2'd0, 4'd6, 16'hFFC0, 16'h0000},
        '{2'd0, 4'd8, 16'hFF00, 16'h0000},
        '{2'd0, 4'd3, 16'hFFFA, 16'h0000},
        '{2'd1, 4'd0, 16'h0000, 16'h0000},
        '{2'd2, 4'd5, 16'h0000, 16'h0001},
        '{2'd2, 4'd6, 16'h0000, 16'h0004},
        '{2'd0, 4'd8, 16'hFF00, 16'h0000},
        '{2'd1, 4'd7, 16'h1234, 16'h0000},
        '{2'd0, 4'd6, 16'h0000, 16'h0000},
        '{2'd2, 4'd3, 16'h0000, 16'h0010},
        '{2'd3, 4'd3, 16'hFFF8, 16'h0000}
    };

    logic        clk = 0, rst_n = 0, start = 0, byte_vld = 0;
    logic [1:0]  mode = 0;
    logic [3:0]  nbits = 0;
    logic [15:0] addend = 0, add_val = 0;
    logic [7:0]  byte_dat;
    logic        byte_req, done;
    logic [15:0] symbol, dest;

    logic [7:0]  stream [4096];
    int          ptr = 0;
    int          cyc = 0;
    int          checks = 0, fails = 0;

    logic [31:0] m_rng, m_code;
    logic [10:0] m_prob [256];
    int          m_ptr;
    logic [15:0] m_sym, m_dest;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign byte_dat = stream[ptr];

    bt_tree_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .nbits(nbits),
        .addend(addend), .add_val(add_val), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .byte_req(byte_req), .symbol(symbol), .dest(dest), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && byte_req && byte_vld) ptr <= ptr + 1;
    end

    // byte source with a fixed gap pattern (R11 stall)
    always @(negedge clk) byte_vld <= ((cyc % 5) != 3);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_bit(input logic [7:0] idx, output logic b);
        logic [31:0] bound;
        logic [10:0] p;
        if (m_rng < 32'h0100_0000) begin
            m_rng  = m_rng << 8;
            m_code = (m_code << 8) | 32'(stream[m_ptr]);
            m_ptr++;
        end
        p     = m_prob[idx];
        bound = (m_rng >> 11) * 32'(p);
        b     = (m_code >= bound);
        if (b) begin
            m_rng  = m_rng - bound;
            m_code = m_code - bound;
            m_prob[idx] = p - (p >> 5);
        end else begin
            m_rng = bound;
            m_prob[idx] = p + 11'((12'd2048 - {1'b0, p}) >> 5);
        end
    endtask

    task automatic m_op(input vec_t v);
        logic b;
        if (v.mode == 2'd1) begin
            m_sym = 0;
            for (int i = 0; i < 4; i++) begin
                m_bit(m_sym[7:0] + (8'd1 << i), b);
                m_sym = m_sym + (16'(b) << i);
            end
        end else if (v.mode == 2'd2) begin
            m_sym = 1; m_dest = 0;
            for (int i = 0; i < int'(v.n); i++) begin
                m_bit(m_sym[7:0], b);
                m_sym = {m_sym[14:0], b};
                if (b) m_dest = m_dest + (v.addv << i);
            end
        end else begin
            m_sym = 1;
            for (int i = 0; i < int'(v.n); i++) begin
                m_bit(m_sym[7:0], b);
                m_sym = {m_sym[14:0], b};
            end
            m_sym = m_sym + v.addend;
        end
    endtask

    // Issue one request, optionally poke a stray start while busy (R10), check the result.
    task automatic run_op(input vec_t v, input bit poke, input string tag);
        int w;
        @(negedge clk);
        start = 1; mode = v.mode; nbits = v.n; addend = v.addend; add_val = v.addv;
        @(negedge clk);
        start = poke; mode = 2'd0; nbits = 4'd3; addend = 16'h5555; add_val = 16'h7;
        @(negedge clk);
        start = 0;
        m_op(v);
        w = 0;
        while (!done && w < 2000) begin @(negedge clk); w++; end
        chk(done == 1'b1, {tag, " done"}, 32'(done), 32'd1);
        chk(symbol == m_sym, {tag, " symbol"}, 32'(symbol), 32'(m_sym));
        chk(dest == m_dest, {tag, " dest"}, 32'(dest), 32'(m_dest));
        if (v.mode != 2'd1 && v.mode != 2'd2 && v.addend == (16'h0 - (16'd1 << v.n)))
            chk(symbol < (16'd1 << v.n), "R4 range", 32'(symbol), 32'(1) << v.n);
        @(negedge clk);
        chk(done == 1'b0, "R9 pulse", 32'(done), 32'd0);
        repeat (2) @(negedge clk);
        chk(symbol == m_sym, "R9 hold", 32'(symbol), 32'(m_sym));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        lf = 16'hACE1;
        stream[0] = 8'h00;
        for (int i = 1; i < 4096; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            stream[i] = lf[7:0] ^ lf[15:8];
        end
        for (int i = 0; i < 256; i++) m_prob[i] = 11'd1024;
        m_rng = 32'hFFFF_FFFF; m_code = 0; m_dest = 0;
        for (int i = 0; i < 5; i++) m_code = (m_code << 8) | 32'(stream[i]);
        m_ptr = 5;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(symbol == 16'd0, "R1 symbol", 32'(symbol), 0);
        chk(dest == 16'd0, "R1 dest", 32'(dest), 0);
        chk(byte_req == 1'b1, "R1 byte_req", 32'(byte_req), 1);
        rst_n = 1;
        // R2 start during initialisation is dropped
        start = 1; mode = 2'd0; nbits = 4'd3;
        @(negedge clk);
        start = 0;
        begin
            bit seen;
            seen = 0;
            repeat (20) begin @(negedge clk); if (done) seen = 1; end
            chk(!seen, "R2 start during init", 32'(seen), 0);
            chk(ptr == 5, "R2 init bytes", 32'(ptr), 5);
        end
        // R11 no request when idle
        chk(byte_req == 1'b0, "R11 idle", 32'(byte_req), 0);

        // R3 R4 R5 R6 R7 R8 vector walk
        for (int k = 0; k < NVEC; k++)
            run_op(VECS[k], (k % 3) == 1, $sformatf("R7 R8 vec%0d mode%0d (R3/R5/R6)", k, VECS[k].mode));
        // R10 stray starts on a long sequence; R8 heavy reuse of nodes
        for (int k = 0; k < 24; k++)
            run_op(VECS[k % NVEC], 1'b1, $sformatf("R10 rep%0d", k));
        chk(ptr == m_ptr, "R11 bytes consumed", 32'(ptr), 32'(m_ptr));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule